// File: doc/BRIEF.md
# Thermometer-Code Time-Difference Capture

This block measures how long a remote node's message takes to arrive, counted in local clock ticks from the local round-start pulse. Internally it is a chain of B flag stages that fills by one position on every tick. Each stage is set-only, and every stage is cleared when a new round begins. When the stop event arrives, the whole chain freezes at once. The result is a unary (thermometer) word. An uncertain stop can therefore only affect the single boundary bit, never the higher positions.

A round-start pulse clears the chain and arms the measurement. An already-synchronised stop pulse ends it. A separate clear input returns the block to idle. If the chain fills before any stop arrives, the block reports all ones and raises an overflow flag. The captured word stays on the output until the next round start or clear. B must be chosen so that the chain covers the largest time difference expected in a correctly executing round.

Top module: `therm_capture`

## Requirements
- R1: The output word encodes a count k (0..B) as ones in bit positions 0..k-1 and zeros in positions k..B-1, so bit 0 is the first to set.
- R2: While a measurement runs, no stage that is set ever returns to zero.
- R3: After a round start is sampled, each later rising edge at which stop is low adds exactly one set stage, until the chain is full.
- R4: A stop sampled while measuring freezes every stage at the same edge. The word then holds the number of edges between the round-start edge and the stop edge, and valid is high from the next cycle with overflow low.
- R5: Once captured, the word, valid and overflow stay unchanged until the next round start or clear, and later stop pulses have no effect.
- R6: If the chain is already all ones at an edge where stop is low, the measurement ends with valid and overflow both high and the word all ones.
- R7: Clear forces the word to zero, drops valid and overflow, and ends any measurement. It takes priority over a simultaneous round start or stop.
- R8: During and after reset the word is zero, valid and overflow are low, and no measurement runs.
- R9: A round start, whether the block is idle, measuring or holding a result, clears the word and both flags and restarts counting.
- R10: A stop pulse while no measurement is armed has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; one stage fills per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| round_start_i | input | 1 | One-cycle pulse that clears the chain and begins a measurement |
| stop_i | input | 1 | Synchronised arrival pulse of the remote message |
| clear_i | input | 1 | Returns the block to idle with an empty chain |
| therm_o | output | B | Thermometer-coded measurement, bit 0 first |
| valid_o | output | 1 | A measurement has ended and therm_o holds its result |
| ovf_o | output | 1 | The chain filled before the stop arrived |

## Verification
Stage errors appear directly on therm_o. A stage that clears, or is set out of turn, leaves a gap in the thermometer word or a count that is off by one, and this shows in the cycle right after the faulty edge. A wrong frozen state shows as a word that keeps growing after the stop, or as valid that rises late or not at all. A wrong full-detection shows as overflow rising on an exact-length stop, or as overflow not rising one edge after the chain fills. The bench compares all three outputs against a behavioural count model on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/therm_capture.sv
module therm_capture #(
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         round_start_i,
  input  logic         stop_i,
  input  logic         clear_i,
  output logic [B-1:0] therm_o,
  output logic         valid_o,
  output logic         ovf_o
);

  logic [B-1:0] chain_q;
  logic         run_q, valid_q, ovf_q;
  logic [B-1:0] grow;
  logic         full;

  assign grow    = chain_q | {chain_q[B-2:0], 1'b1};
  assign full    = chain_q[B-1];
  assign therm_o = chain_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clear_i) begin
      chain_q <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (round_start_i) begin
      chain_q <= '0;
      run_q   <= 1'b1;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (run_q) begin
      if (stop_i) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end else if (full) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
        ovf_q   <= 1'b1;
      end else begin
        chain_q <= grow;
      end
    end
  end

  AST_THERMO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_o & (therm_o + 1'b1)) == '0)); // R1

  AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !clear_i && !round_start_i) |=> ((therm_o & $past(therm_o)) == $past(therm_o))); // R2

  AST_STOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stop_i && !clear_i && !round_start_i) |=> (valid_o && !ovf_o && $stable(therm_o))); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !clear_i && !round_start_i) |=> ($stable(therm_o) && valid_o && $stable(ovf_o))); // R5

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (valid_o && (&therm_o))); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (therm_o == '0 && !valid_o && !ovf_o)); // R7

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (round_start_i && !clear_i) |=> (therm_o == '0 && !valid_o && !ovf_o)); // R9

endmodule

// File: tb/therm_capture_tb.sv
module therm_capture_tb_top;
  localparam int B = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic round_start_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0;
  logic [B-1:0] therm_o;
  logic valid_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_run = 0, m_val = 0, m_ovf = 0;
  bit done = 0;

  always #2 clk = ~clk;

  therm_capture #(.B(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .round_start_i(round_start_i), .stop_i(stop_i),
    .clear_i(clear_i), .therm_o(therm_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  function automatic logic [B-1:0] expect_word(int k);
    logic [B-1:0] w = '0;
    for (int i = 0; i < B; i++) if (i < k) w[i] = 1'b1;
    return w;
  endfunction

  task automatic check_outputs(string tag);
    logic [B-1:0] ew = expect_word(m_cnt);
    n_chk++;
    if (therm_o !== ew || valid_o !== m_val || ovf_o !== m_ovf) begin
      n_fail++;
      $display("FAIL %s: word=%b valid=%b ovf=%b expected word=%b valid=%b ovf=%b",
               tag, therm_o, valid_o, ovf_o, ew, m_val, m_ovf);
    end
  endtask

  task automatic cyc(bit rs, bit st, bit cl, string tag);
    round_start_i = rs; stop_i = st; clear_i = cl;
    @(posedge clk);
    if (cl) begin m_cnt = 0; m_run = 0; m_val = 0; m_ovf = 0; end
    else if (rs) begin m_cnt = 0; m_run = 1; m_val = 0; m_ovf = 0; end
    else if (m_run) begin
      if (st) begin m_run = 0; m_val = 1; end
      else if (m_cnt == B) begin m_run = 0; m_val = 1; m_ovf = 1; end
      else m_cnt++;
    end
    @(negedge clk);
    round_start_i = 0; stop_i = 0; clear_i = 0;
    check_outputs(tag);
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R8 reset");
    rst_n = 1'b1;
    cyc(0, 0, 0, "R8 after reset");
    cyc(0, 1, 0, "R10 idle stop");
    cyc(0, 0, 0, "R10 idle stop");

    cyc(1, 0, 0, "R9 start");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R2/R3 count");
    cyc(0, 1, 0, "R4 stop at 3");
    for (int i = 0; i < 3; i++) cyc(0, (i == 1), 0, "R5 hold");

    cyc(1, 0, 0, "R9 restart after capture");
    cyc(0, 1, 0, "R4 stop at 0");
    cyc(0, 0, 0, "R5 hold zero");

    for (int len = 1; len <= B; len++) begin
      cyc(1, 0, 0, "R9 start");
      for (int i = 0; i < len; i++) cyc(0, 0, 0, "R1/R3 fill");
      cyc(0, 1, 0, "R4 stop length sweep");
      cyc(0, 0, 0, "R5 hold sweep");
    end

    cyc(1, 0, 0, "R9 start");
    for (int i = 0; i < B + 4; i++) cyc(0, 0, 0, "R6 overflow");
    cyc(0, 1, 0, "R5 stop after overflow");

    cyc(1, 0, 0, "R9 start");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R3 count");
    cyc(1, 0, 0, "R9 restart while running");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, "R3 recount");
    cyc(0, 0, 1, "R7 clear mid run");
    cyc(0, 0, 0, "R7 idle after clear");
    cyc(1, 0, 1, "R7 clear beats start");
    cyc(0, 0, 0, "R7 no run after clear");
    cyc(1, 0, 0, "R9 start");
    cyc(0, 0, 0, "R3 count");
    cyc(0, 1, 1, "R7 clear beats stop");
    cyc(0, 0, 0, "R7 idle");
    cyc(1, 0, 0, "R9 start");
    cyc(0, 0, 0, "R3 count");
    cyc(0, 1, 0, "R4 stop");
    cyc(0, 0, 1, "R7 clear result");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule